// File: doc/BRIEF.md
# Multi-Channel Pulse-Width / Rate-Multiplier DAC Generator

This block produces one 10-bit-resolution pulse train per channel. Each train is meant to pass through an external RC low-pass filter, which turns it into an analog voltage set by the channel's duty code. A single free-running counter paces every channel. Its low six bits mark out a 64-clock base period. Its next four bits number the periods within a 16-period frame.

Each channel's code is split into two fields. The upper six bits set how many clocks of each base period the output stays high. The lower four bits add one extra high clock in a chosen subset of the 16 periods of a frame. The average over 1024 clocks is therefore exactly the 10-bit code. Software writes each channel's code and three control bits through a single-cycle write port. The control bits are polarity inversion, a logic-output mode, and the level to drive in that mode.

Top module: `pwm_brm_dac`

## Requirements
- R1: While reset is held, and through the first base period after it, every output is low. Reset clears the counter, every code and every control bit.
- R2: The counter advances by one on every clock with no stop condition. Its bits [5:0] wrap every 64 clocks and set the base period.
- R3: In pulse mode, the pre-inversion level goes high at counter bits [5:0] = 0 whenever the effective width of the period is nonzero.
- R4: In pulse mode, the pre-inversion level goes low in the cycle where counter bits [5:0] equal the effective width. An effective width of 64 keeps it high for the whole period.
- R5: Code bits [9:4] are the base width and code bits [3:0] are the rate-multiplier weight.
- R6: The effective width of a period is the base width plus one when the period index s = counter bits [9:6] is selected, and the base width otherwise. Weight bit 3 selects s with s[0]=1. Weight bit 2 selects s[1:0]=2'b10. Weight bit 1 selects s[2:0]=3'b100. Weight bit 0 selects s=4'b1000.
- R7: Over any frame of 1024 clocks aligned to counter bits [9:0] = 0, a pulse-mode channel with a fixed code and no inversion is high for exactly the code's number of clocks.
- R8: A written code is used from the start of the next base period. A write in the middle of a period changes neither that period's high time nor its pattern.
- R9: A code of 0 keeps the pre-inversion level low for the entire period.
- R10: With the invert bit set, the output is the complement of the pre-inversion level. A control write reaches the output two clocks after the write cycle.
- R11: With the logic-mode bit set, the output equals the level bit and the pulse sequence has no effect on it.
- R12: A write to one channel does not change the output of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one channel's code and controls |
| wr_ch | input | CH_W (2) | Index of the channel being written |
| wr_code | input | CODE_W (10) | Duty code: [9:4] width, [3:0] rate weight |
| wr_inv | input | 1 | Invert output polarity |
| wr_lvl_mode | input | 1 | 1 = drive the level bit instead of pulses |
| wr_lvl | input | 1 | Output level used in logic mode |
| dac_out | output | NCH (4) | Registered per-channel outputs |

## Verification
The bench predicts every output bit in every cycle from the counter position and the code captured at each period start. It also sums each channel's high time over aligned 1024-clock frames. Codes 0 and 1023 are covered: a design that mishandled the width-64 case would drop a clock in the selected periods, and one that cleared on a zero width would emit a one-clock glitch. All sixteen rate weights are swept. A wrong bit-reversed selection leaves the frame sums right but puts the extra clocks in the wrong periods, and the per-cycle comparison catches that. Codes are rewritten mid-period and one channel is written repeatedly while the others are watched. A design that loaded codes immediately would produce truncated or doubled periods, and a bad write decode would disturb the neighbouring channels.

// File: rtl/pwmdac_pkg.sv
package pwmdac_pkg;

    // per-channel control bits
    typedef struct packed {
        logic inv;       // invert the pulse output
        logic lvl_mode;  // drive lvl instead of the pulse train
        logic lvl;       // level in logic mode
    } ch_ctl_t;

    localparam int unsigned DEF_NCH   = 4;
    localparam int unsigned DEF_PW_W  = 6;
    localparam int unsigned DEF_BRM_W = 4;
    localparam int unsigned DEF_CNT_W = 12;

endpackage

// File: rtl/pwmdac_counter.sv
module pwmdac_counter #(
    parameter int unsigned CNT_W = 12,
    parameter int unsigned PW_W  = 6,
    parameter int unsigned BRM_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt,
    output logic [PW_W-1:0]  nxt_pw,
    output logic [BRM_W-1:0] nxt_slot
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.cnt = s_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign cnt      = s_q.cnt;
    assign nxt_pw   = s_d.cnt[PW_W-1:0];
    assign nxt_slot = s_d.cnt[PW_W+BRM_W-1:PW_W];

endmodule

// File: rtl/pwmdac_brm_sel.sv
module pwmdac_brm_sel #(
    parameter int unsigned BRM_W = 4
) (
    input  logic [BRM_W-1:0] weight,
    input  logic [BRM_W-1:0] slot,
    output logic             extra
);

    logic [BRM_W-1:0] hit;

    // weight bit (BRM_W-1-i) owns the slots whose low i+1 bits are 1 followed by i zeros
    for (genvar i = 0; i < BRM_W; i++) begin : g_lane
        localparam logic [BRM_W-1:0] MASK = BRM_W'((1 << (i + 1)) - 1);
        localparam logic [BRM_W-1:0] PICK = BRM_W'(1 << i);
        assign hit[i] = weight[BRM_W-1-i] && ((slot & MASK) == PICK);
    end

    assign extra = |hit;

endmodule

// File: rtl/pwmdac_channel.sv
module pwmdac_channel
    import pwmdac_pkg::*;
#(
    parameter  int unsigned PW_W   = 6,
    parameter  int unsigned BRM_W  = 4,
    localparam int unsigned CODE_W = PW_W + BRM_W,
    localparam int unsigned WID_W  = PW_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  ch_ctl_t           wr_ctl,
    input  logic [PW_W-1:0]   nxt_pw,
    input  logic [BRM_W-1:0]  nxt_slot,
    output logic              dac_pin,
    output logic              raw,
    output logic [CODE_W-1:0] act_code,
    output logic [WID_W-1:0]  width,
    output logic              lvl_mode,
    output logic              lvl
);

    typedef struct packed {
        logic [CODE_W-1:0] shadow;  // last written code
        logic [CODE_W-1:0] active;  // code of the running period
        logic [WID_W-1:0]  width;   // high clocks in the running period
        logic              raw;     // pulse level before polarity
        ch_ctl_t           ctl;
        logic              pin;
    } st_t;

    st_t  s_d, s_q;
    logic brm_extra;

    pwmdac_brm_sel #(.BRM_W(BRM_W)) u_brm (
        .weight (s_q.shadow[BRM_W-1:0]),
        .slot   (nxt_slot),
        .extra  (brm_extra)
    );

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.shadow = wr_code;
            s_d.ctl    = wr_ctl;
        end
        if (nxt_pw == '0) begin
            // period start: adopt the pending code and raise if width is nonzero
            s_d.active = s_q.shadow;
            s_d.width  = {1'b0, s_q.shadow[CODE_W-1:BRM_W]} + WID_W'(brm_extra);
            s_d.raw    = (s_d.width != '0);
        end else if ({1'b0, nxt_pw} == s_q.width) begin
            s_d.raw = 1'b0;
        end
        s_d.pin = s_q.ctl.lvl_mode ? s_q.ctl.lvl : (s_d.raw ^ s_q.ctl.inv);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign dac_pin  = s_q.pin;
    assign raw      = s_q.raw;
    assign act_code = s_q.active;
    assign width    = s_q.width;
    assign lvl_mode = s_q.ctl.lvl_mode;
    assign lvl      = s_q.ctl.lvl;

endmodule

// File: rtl/pwm_brm_dac.sv
module pwm_brm_dac
    import pwmdac_pkg::*;
#(
    parameter  int unsigned NCH    = DEF_NCH,
    parameter  int unsigned PW_W   = DEF_PW_W,
    parameter  int unsigned BRM_W  = DEF_BRM_W,
    parameter  int unsigned CNT_W  = DEF_CNT_W,
    localparam int unsigned CODE_W = PW_W + BRM_W,
    localparam int unsigned WID_W  = PW_W + 1,
    localparam int unsigned CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              wr_inv,
    input  logic              wr_lvl_mode,
    input  logic              wr_lvl,
    output logic [NCH-1:0]    dac_out
);

    logic [CNT_W-1:0]      cnt_q;
    logic [PW_W-1:0]       nxt_pw;
    logic [BRM_W-1:0]      nxt_slot;
    logic [NCH-1:0]        raw_vec;
    logic [NCH-1:0]        mode_vec;
    logic [NCH-1:0]        lvl_vec;
    logic [NCH*CODE_W-1:0] act_flat;
    logic [NCH*WID_W-1:0]  width_flat;
    ch_ctl_t               wr_ctl;

    assign wr_ctl = '{inv: wr_inv, lvl_mode: wr_lvl_mode, lvl: wr_lvl};

    pwmdac_counter #(.CNT_W(CNT_W), .PW_W(PW_W), .BRM_W(BRM_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cnt      (cnt_q),
        .nxt_pw   (nxt_pw),
        .nxt_slot (nxt_slot)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic sel;
        assign sel = wr_en && (wr_ch == CH_W'(g));

        pwmdac_channel #(.PW_W(PW_W), .BRM_W(BRM_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (sel),
            .wr_code  (wr_code),
            .wr_ctl   (wr_ctl),
            .nxt_pw   (nxt_pw),
            .nxt_slot (nxt_slot),
            .dac_pin  (dac_out[g]),
            .raw      (raw_vec[g]),
            .act_code (act_flat[g*CODE_W +: CODE_W]),
            .width    (width_flat[g*WID_W +: WID_W]),
            .lvl_mode (mode_vec[g]),
            .lvl      (lvl_vec[g])
        );
    end

endmodule

// File: rtl/pwm_brm_dac_chk.sv
module pwm_brm_dac_chk #(
    parameter  int unsigned NCH    = 4,
    parameter  int unsigned PW_W   = 6,
    parameter  int unsigned BRM_W  = 4,
    parameter  int unsigned CNT_W  = 12,
    localparam int unsigned CODE_W = PW_W + BRM_W,
    localparam int unsigned WID_W  = PW_W + 1
) (
    input logic              clk,
    input logic              rst,
    input logic [CNT_W-1:0]  cnt,
    input logic [NCH*CODE_W-1:0] act,
    input logic [NCH-1:0]    raw,
    input logic [NCH*WID_W-1:0] width,
    input logic [NCH-1:0]    mode,
    input logic [NCH-1:0]    lvl,
    input logic [NCH-1:0]    pin
);

    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= 1'b1;
    end

    p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst || !armed_q)
        cnt == CNT_W'($past(cnt) + CNT_W'(1)));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        p_rise_r3: assert property (@(posedge clk) disable iff (rst || !armed_q)
            $rose(raw[g]) |-> (cnt[PW_W-1:0] == '0));

        p_fall_r4: assert property (@(posedge clk) disable iff (rst || !armed_q)
            $fell(raw[g]) |-> ({1'b0, cnt[PW_W-1:0]} == width[g*WID_W +: WID_W]));

        p_latch_r8: assert property (@(posedge clk) disable iff (rst || !armed_q)
            !$stable(act[g*CODE_W +: CODE_W]) |-> (cnt[PW_W-1:0] == '0));

        p_zero_r9: assert property (@(posedge clk) disable iff (rst || !armed_q)
            (act[g*CODE_W +: CODE_W] == '0) |-> !raw[g]);

        p_logic_r11: assert property (@(posedge clk) disable iff (rst || !armed_q)
            mode[g] |=> (pin[g] == $past(lvl[g])));
    end

endmodule

bind pwm_brm_dac pwm_brm_dac_chk #(
    .NCH(NCH), .PW_W(PW_W), .BRM_W(BRM_W), .CNT_W(CNT_W)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .cnt   (cnt_q),
    .act   (act_flat),
    .raw   (raw_vec),
    .width (width_flat),
    .mode  (mode_vec),
    .lvl   (lvl_vec),
    .pin   (dac_out)
);

// File: tb/pwm_brm_dac_tb.sv
module pwm_brm_dac_tb;

    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic [1:0]     wr_ch = '0;
    logic [9:0]     wr_code = '0;
    logic           wr_inv = 1'b0;
    logic           wr_lvl_mode = 1'b0;
    logic           wr_lvl = 1'b0;
    logic [NCH-1:0] dac_out;

    always #4 clk = ~clk;

    pwm_brm_dac u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_code(wr_code),
        .wr_inv(wr_inv), .wr_lvl_mode(wr_lvl_mode), .wr_lvl(wr_lvl), .dac_out(dac_out)
    );

    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit iso = 1'b0;
    int pend[NCH];
    int act[NCH];
    int fsum[NCH];
    int ctl_at[NCH];
    bit [2:0] cpend[NCH];   // {inv, mode, level}
    bit [2:0] ccur[NCH];
    bit fclean[NCH];
    bit fresh[NCH];

    initial begin
        for (int i = 0; i < NCH; i++) begin
            pend[i] = 0; act[i] = 0; fsum[i] = 0; ctl_at[i] = 0;
            cpend[i] = 3'b000; ccur[i] = 3'b000; fclean[i] = 1'b0; fresh[i] = 1'b0;
        end
    end

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // extra clock selection (R6), computed arithmetically
    function automatic int extra_of(input int w, input int s);
        if ((w & 8) != 0 && (s % 2) == 1) return 1;
        if ((w & 4) != 0 && (s % 4) == 2) return 1;
        if ((w & 2) != 0 && (s % 8) == 4) return 1;
        if ((w & 1) != 0 && s == 8)       return 1;
        return 0;
    endfunction

    task automatic check(input bit ok, input string tag, input int ch, input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s ch%0d cyc=%0d got=%0d exp=%0d", tag, ch, cyc, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            for (int ch = 0; ch < NCH; ch++)
                check(dac_out[ch] == 1'b0, "R1", ch, int'(dac_out[ch]), 0);
        end else begin
            int p, s, f, eff, e, fx;
            string tag;
            p = cyc % 64;
            s = (cyc / 64) % 16;
            f = cyc % 1024;
            for (int ch = 0; ch < NCH; ch++) begin
                if (cyc == ctl_at[ch]) ccur[ch] = cpend[ch];
                if (p == 0) begin
                    fresh[ch] = (act[ch] != pend[ch]);
                    act[ch]   = pend[ch];
                end
                if (f == 0) begin
                    fsum[ch]   = 0;
                    fclean[ch] = (cyc >= ctl_at[ch]);
                end
                // R5: width = code[9:4], weight = code[3:0]
                eff = act[ch] / 16 + extra_of(act[ch] % 16, s);
                if (ccur[ch][1]) e = int'(ccur[ch][0]);
                else             e = ((p < eff) ? 1 : 0) ^ int'(ccur[ch][2]);
                if (cyc < 64)                 tag = "R1";
                else if (ccur[ch][1])         tag = "R11";
                else if (ccur[ch][2])         tag = "R10";
                else if (fresh[ch])           tag = "R8";
                else if (act[ch] == 0)        tag = "R9";
                else if (p == 0)              tag = "R2 R3";
                else if (extra_of(act[ch] % 16, s) == 1) tag = "R6";
                else                          tag = "R4";
                check(int'(dac_out[ch]) == e, tag, ch, int'(dac_out[ch]), e);
                fsum[ch] += int'(dac_out[ch]);
                if (f == 1023 && fclean[ch]) begin
                    if (ccur[ch][1])      fx = ccur[ch][0] ? 1024 : 0;
                    else if (ccur[ch][2]) fx = 1024 - act[ch];
                    else                  fx = act[ch];
                    check(fsum[ch] == fx, (iso && ch != 0) ? "R12" : "R5 R7", ch, fsum[ch], fx);
                end
            end
        end
    end

    task automatic wr(input int ch, input int code, input bit inv, input bit md, input bit lv);
        @(posedge clk); #1;
        while ((cyc % 64) < 2 || (cyc % 64) > 55) begin
            @(posedge clk); #1;
        end
        wr_en = 1'b1; wr_ch = 2'(ch); wr_code = 10'(code);
        wr_inv = inv; wr_lvl_mode = md; wr_lvl = lv;
        pend[ch]   = code;
        cpend[ch]  = {inv, md, lv};
        ctl_at[ch] = cyc + 2;
        fclean[ch] = 1'b0;
        @(posedge clk); #1;
        wr_en = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic set4(input int c0, input int c1, input int c2, input int c3);
        wr(0, c0, 0, 0, 0); wr(1, c1, 0, 0, 0); wr(2, c2, 0, 0, 0); wr(3, c3, 0, 0, 0);
    endtask

    task automatic frames(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            while ((cyc % 1024) != 1023) @(negedge clk);
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        frames(1);                               // R1: idle frame, all zero
        set4(0, 1023, 1, 512);                   // extremes and single clocks
        frames(2);
        set4(15, 16, 1008, 341);                 // weight-only, width-only, mixes
        frames(2);
        for (int r = 0; r < 4; r++) begin        // all 16 weights, varied widths
            for (int ch = 0; ch < NCH; ch++)
                wr(ch, ((r * 13 + ch * 7 + 1) % 64) * 16 + r * 4 + ch, 0, 0, 0);
            frames(2);
        end
        // R10 inversion, R11 logic levels
        wr(0, 100, 1, 0, 0); wr(1, 0, 1, 0, 0); wr(2, 700, 0, 1, 1); wr(3, 900, 0, 1, 0);
        frames(2);
        set4(200, 300, 400, 500);
        frames(2);
        // R8 mid-period rewrites on ch0, R12 others untouched
        iso = 1'b1;
        for (int k = 0; k < 6; k++) begin
            wr(0, 37 + k * 151, 0, 0, 0);
            repeat (90 + k * 17) @(posedge clk);
        end
        frames(2);
        iso = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog cyc=%0d got=running exp=done", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule